// File: doc/BRIEF.md
# Keypad Event Queue

This block holds keypad press and release events in a sixteen-slot circular byte buffer until a host collects them. Each accepted event is packed into one byte: the key number in the low seven bits and the key direction in the top bit. Every accepted event produces a one-cycle keypad interrupt pulse that the host-side status logic can latch.

The host has two ways to read. A consuming read advances the head pointer by one, shrinks the fill count and returns the slot the head now points at. A peek at an offset returns a slot relative to the head and leaves every pointer alone. A flush, issued when the host writes the configuration, empties the buffer.

When an event arrives while all sixteen slots are full, the event is dropped. The block pulses an overflow error and sets a lock. While the lock is set, all new events are discarded without any pulse. The lock stays set until the host issues an error clear or a flush.

Top module: `key_event_queue`

## Requirements
- R1: After synchronous reset the fill count is 0, the lock is clear, and rdValid, rdData, kpIntSet and ovfErrPulse are all 0.
- R2: A stored event byte holds evtCode in bits 6:0. Bit 7 is 1 when evtPressed is 1 and 0 when evtPressed is 0.
- R3: The buffer holds at most 16 entries. The head and tail indices wrap modulo 16, so filling and draining across slot 15 keeps the events in arrival order.
- R4: An event that arrives while the count is 16 is not stored. It makes ovfErrPulse high for one cycle and sets ovfLock.
- R5: While ovfLock is high, events are discarded: the count does not change, and neither kpIntSet nor ovfErrPulse pulses. An errClear clears the lock.
- R6: Every stored event makes kpIntSet high for exactly one cycle.
- R7: A consuming read with count of 2 or more advances the head by one and decrements the count. It returns the entry at the new head position.
- R8: A consuming read with count of 1 or less returns 0x00 and changes neither the head nor the count.
- R9: A peek at offset k, with k below the count, returns the entry at (head + k) mod 16 and moves no pointer. A peek with k equal to or above the count returns 0x00.
- R10: A flush sets the head and the count to 0 and clears ovfLock. It takes precedence over every other request in the same cycle. Reads in that cycle return 0x00, and events in that cycle are dropped without a pulse.
- R11: An event and a successful consuming read in the same cycle are both carried out, and the count is left unchanged.
- R12: rdValid is high in the cycle after each consuming-read or peek request. When both requests are present, the consuming read is served and the peek is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | Key event strobe |
| evtCode | input | 7 | Key number of the event |
| evtPressed | input | 1 | 1 = key pressed, 0 = key released |
| popReq | input | 1 | Consuming read request |
| peekReq | input | 1 | Non-consuming read request |
| peekOfs | input | 5 | Peek offset from the head |
| flush | input | 1 | Empty the buffer (configuration write) |
| errClear | input | 1 | Clear the overflow lock |
| rdValid | output | 1 | Read result valid |
| rdData | output | 8 | Read result byte |
| fillCount | output | 5 | Number of entries held |
| kpIntSet | output | 1 | One-cycle pulse per stored event |
| ovfErrPulse | output | 1 | One-cycle pulse on overflow |
| ovfLock | output | 1 | Overflow lock state |

## Verification
Every output is a register updated on the same rising edge that samples the request. The read byte, rdValid, both pulses, the lock and the new count are therefore all due exactly one edge after the stimulus. The bench applies each request on a falling edge, lets one rising edge pass, and compares all six outputs on the following falling edge. The expected values come from a behavioural queue model that is updated in the same step. A peek issued in a later cycle confirms that a consuming read or a dropped event left the entries where they were.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  localparam int DEPTH   = 16;
  localparam int CODE_W  = 7;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int CNT_W   = ADDR_W + 1;
  localparam int ENTRY_W = CODE_W + 1;

  typedef struct packed {
    logic              push;
    logic [ADDR_W-1:0] wrIdx;
    logic              rdReq;
    logic              rdEn;
    logic [ADDR_W-1:0] rdIdx;
  } keyq_strobe_t;
endpackage

// File: rtl/keyq_ctrl.sv
module keyq_ctrl
  import keyq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evtValid,
  input  logic             popReq,
  input  logic             peekReq,
  input  logic [CNT_W-1:0] peekOfs,
  input  logic             flush,
  input  logic             errClear,
  output keyq_strobe_t     stb,
  output logic [CNT_W-1:0] fillCount,
  output logic             kpIntSet,
  output logic             ovfErrPulse,
  output logic             ovfLock
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] headPtr;
  logic [CNT_W-1:0]  cnt;
  logic              lockQ;
  logic              pushAcc, storeOk, ovfHit, popOk, peekSel, peekHit;

  always_comb begin
    pushAcc = evtValid & ~lockQ & ~flush;
    storeOk = pushAcc & (cnt != FULL);
    ovfHit  = pushAcc & (cnt == FULL);
    popOk   = ~flush & popReq & (cnt > ONE);
    peekSel = ~flush & ~popReq & peekReq;
    peekHit = peekSel & (peekOfs < cnt);

    stb.push  = storeOk;
    stb.wrIdx = headPtr + cnt[ADDR_W-1:0];
    stb.rdReq = popReq | peekReq;
    stb.rdEn  = popOk | peekHit;
    stb.rdIdx = popOk ? ADDR_W'(headPtr + ADDR_W'(1))
                      : ADDR_W'(headPtr + peekOfs[ADDR_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headPtr     <= '0;
      cnt         <= '0;
      lockQ       <= 1'b0;
      kpIntSet    <= 1'b0;
      ovfErrPulse <= 1'b0;
    end else begin
      kpIntSet    <= storeOk;
      ovfErrPulse <= ovfHit;
      if (flush) begin
        headPtr <= '0;
        cnt     <= '0;
        lockQ   <= 1'b0;
      end else begin
        if (popOk) headPtr <= headPtr + ADDR_W'(1);
        case ({storeOk, popOk})
          2'b10:   cnt <= cnt + ONE;
          2'b01:   cnt <= cnt - ONE;
          default: cnt <= cnt;
        endcase
        if (ovfHit)        lockQ <= 1'b1;
        else if (errClear) lockQ <= 1'b0;
      end
    end
  end

  assign fillCount = cnt;
  assign ovfLock   = lockQ;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  assert_pop_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (popReq && !flush && !evtValid && cnt > ONE) |=> cnt == $past(cnt) - ONE);

  assert_no_pop_small_R8: assert property (@(posedge clk) disable iff (rst)
    (popReq && !flush && !evtValid && cnt <= ONE) |=> $stable(cnt) && $stable(headPtr));

  assert_locked_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (lockQ && evtValid && !popReq && !flush) |=> $stable(cnt) && !kpIntSet);

  assert_ovf_lock_R4: assert property (@(posedge clk) disable iff (rst)
    ovfErrPulse |-> lockQ);

  assert_flush_zero_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0) && !lockQ);

  assert_both_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (evtValid && !lockQ && popReq && !flush && cnt > ONE && cnt < FULL)
      |=> $stable(cnt));
endmodule

// File: rtl/keyq_data.sv
module keyq_data
  import keyq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  keyq_strobe_t       stb,
  input  logic [ENTRY_W-1:0] wrByte,
  output logic               rdValid,
  output logic [ENTRY_W-1:0] rdData
);
  logic [ENTRY_W-1:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[i] <= '0;
      else if (stb.push && stb.wrIdx == ADDR_W'(i))
        slots[i] <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdReq;
      rdData  <= stb.rdEn ? slots[stb.rdIdx] : '0;
    end
  end

  assert_zero_return_R9: assert property (@(posedge clk) disable iff (rst)
    (stb.rdReq && !stb.rdEn) |=> rdData == '0);

  assert_valid_follow_R12: assert property (@(posedge clk) disable iff (rst)
    stb.rdReq |=> rdValid);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import keyq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               evtValid,
  input  logic [CODE_W-1:0]  evtCode,
  input  logic               evtPressed,
  input  logic               popReq,
  input  logic               peekReq,
  input  logic [CNT_W-1:0]   peekOfs,
  input  logic               flush,
  input  logic               errClear,
  output logic               rdValid,
  output logic [ENTRY_W-1:0] rdData,
  output logic [CNT_W-1:0]   fillCount,
  output logic               kpIntSet,
  output logic               ovfErrPulse,
  output logic               ovfLock
);
  keyq_strobe_t stb;
  logic [ENTRY_W-1:0] wrByte;

  assign wrByte = {evtPressed, evtCode};

  keyq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .popReq(popReq),
    .peekReq(peekReq), .peekOfs(peekOfs), .flush(flush), .errClear(errClear),
    .stb(stb), .fillCount(fillCount), .kpIntSet(kpIntSet),
    .ovfErrPulse(ovfErrPulse), .ovfLock(ovfLock)
  );

  keyq_data u_data (
    .clk(clk), .rst(rst), .stb(stb), .wrByte(wrByte),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/key_event_queue_bench.sv
module key_event_queue_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evtValid = 0, evtPressed = 0, popReq = 0, peekReq = 0, flush = 0, errClear = 0;
  logic [6:0] evtCode = '0;
  logic [4:0] peekOfs = '0;
  logic       rdValid, kpIntSet, ovfErrPulse, ovfLock;
  logic [7:0] rdData;
  logic [4:0] fillCount;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] mq [16];
  int mHead = 0, mCnt = 0;
  bit mLock = 0;

  always #4 clk = ~clk;

  key_event_queue u_key_event_queue (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtCode(evtCode),
    .evtPressed(evtPressed), .popReq(popReq), .peekReq(peekReq),
    .peekOfs(peekOfs), .flush(flush), .errClear(errClear),
    .rdValid(rdValid), .rdData(rdData), .fillCount(fillCount),
    .kpIntSet(kpIntSet), .ovfErrPulse(ovfErrPulse), .ovfLock(ovfLock)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: apply on a falling edge, model it, compare after the next rising edge.
  task automatic cyc(input bit e, input logic [6:0] code, input bit pr, input bit pop,
                     input bit pk, input int ofs, input bit fl, input bit clr,
                     input string tag);
    bit expRv, expKp, expOvf, pushOk, popOk;
    int expRd;
    evtValid = e; evtCode = code; evtPressed = pr; popReq = pop;
    peekReq = pk; peekOfs = 5'(ofs); flush = fl; errClear = clr;
    expRv = pop | pk; expRd = 0; expKp = 0; expOvf = 0;
    if (fl) begin
      mHead = 0; mCnt = 0; mLock = 0;
    end else begin
      pushOk = e && !mLock && mCnt < 16;
      expOvf = e && !mLock && mCnt == 16;
      expKp  = pushOk;
      popOk  = pop && mCnt > 1;
      if (popOk)               expRd = mq[(mHead + 1) % 16];
      else if (!pop && pk && ofs < mCnt) expRd = mq[(mHead + ofs) % 16];
      if (pushOk) mq[(mHead + mCnt) % 16] = {pr, code};
      if (popOk) mHead = (mHead + 1) % 16;
      mCnt = mCnt + int'(pushOk) - int'(popOk);
      if (expOvf)   mLock = 1;
      else if (clr) mLock = 0;
    end
    @(posedge clk);
    @(negedge clk);
    evtValid = 0; popReq = 0; peekReq = 0; flush = 0; errClear = 0;
    chk(tag, "rdValid", rdValid, expRv);
    chk(tag, "rdData", rdData, expRd);
    chk(tag, "fillCount", fillCount, mCnt);
    chk(tag, "kpIntSet", kpIntSet, expKp);
    chk(tag, "ovfErrPulse", ovfErrPulse, expOvf);
    chk(tag, "ovfLock", ovfLock, mLock);
  endtask

  task automatic push(input logic [6:0] c, input bit pr, input string tag);
    cyc(1, c, pr, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic pop(input string tag);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, tag);
  endtask
  task automatic peek(input int k, input string tag);
    cyc(0, 0, 0, 0, 1, k, 0, 0, tag);
  endtask

  task automatic t_reset_R1;
    chk("R1", "fillCount", fillCount, 0);
    chk("R1", "ovfLock", ovfLock, 0);
    chk("R1", "rdValid", rdValid, 0);
    chk("R1", "rdData", rdData, 0);
    chk("R1", "kpIntSet", kpIntSet, 0);
    chk("R1", "ovfErrPulse", ovfErrPulse, 0);
  endtask

  task automatic t_format_R2_R6;
    push(7'h3c, 1, "R6");
    push(7'h55, 0, "R6");
    peek(0, "R2");
    chk("R2", "pressed byte", rdData, 8'hbc);
    peek(1, "R2");
    chk("R2", "released byte", rdData, 8'h55);
  endtask

  task automatic t_consume_R7_R8;
    pop("R7");
    chk("R7", "consumed byte", rdData, 8'h55);
    pop("R8");
    chk("R8", "small-count byte", rdData, 0);
    peek(0, "R8");
    chk("R8", "head kept", rdData, 8'h55);
  endtask

  task automatic t_peek_range_R9;
    peek(1, "R9");
    peek(16, "R9");
    push(7'h11, 1, "R9");
    peek(1, "R9");
    chk("R9", "offset 1", rdData, 8'h91);
    peek(2, "R9");
  endtask

  task automatic t_fill_ovf_R3_R4_R5;
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 16; i++) push(7'(i * 5 + 3), i[0], "R3");
    chk("R3", "full count", fillCount, 16);
    push(7'h7f, 1, "R4");
    push(7'h22, 0, "R5");
    push(7'h23, 1, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5");
    for (int i = 0; i < 6; i++) pop("R3");
    for (int i = 0; i < 5; i++) push(7'(i + 100), 1, "R3");
    for (int k = 0; k < 16; k++) peek(k, "R3");
    push(7'h01, 0, "R4");
  endtask

  task automatic t_simul_R11;
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 4; i++) push(7'(i + 40), 0, "R11");
    for (int i = 0; i < 20; i++) cyc(1, 7'(i + 60), i[1], 1, 0, 0, 0, 0, "R11");
    chk("R11", "steady count", fillCount, 4);
    for (int k = 0; k < 5; k++) peek(k, "R11");
  endtask

  task automatic t_flush_R10;
    cyc(1, 7'h33, 1, 1, 0, 0, 1, 0, "R10");
    chk("R10", "flushed count", fillCount, 0);
    for (int i = 0; i < 17; i++) push(7'(i), 1, "R10");
    cyc(1, 7'h44, 0, 0, 1, 0, 1, 0, "R10");
    chk("R10", "lock released", ovfLock, 0);
    push(7'h45, 1, "R10");
  endtask

  task automatic t_pop_peek_R12;
    push(7'h46, 0, "R12");
    push(7'h47, 1, "R12");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R12");
    peek(0, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_R1();
    t_format_R2_R6();
    t_consume_R7_R8();
    t_peek_range_R9();
    t_fill_ovf_R3_R4_R5();
    t_simul_R11();
    t_flush_R10();
    t_pop_peek_R12();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule